// File: doc/BRIEF.md
# PCIe Client Control Register Block

This block is a small register slave placed next to a PCIe controller core. It holds the core's device mode, the link-training enable, the clock-request power controls and the hot-reset training controls. It also gathers two groups of events into status registers: the four legacy INTx lines and two link events, a data-link-layer link-up change and a hot-reset or link-down reset request. Each group has its own mask register and one combined interrupt output. The core's current LTSSM state and link-up indication can be read back through a read-only status word.

Every control register uses half-word write masking. Bits 31:16 of a write select which of bits 15:0 are updated, so software can change one field without a read-modify-write. Status registers are cleared by writing 1. In endpoint use, software can arm a training hold. A reset request from the link then forces the training-enable output low until software writes a release bit. This gives software time to reconfigure before the link retrains.

The bus is a plain 32-bit word interface: address, write strobe and write data are sampled on the rising clock edge. Read data is a combinational function of the address. The reset is synchronous and active low.

Top module: `pcie_client_regs`

## Requirements
- R1: In every control register (offsets 0x000, 0x01C, 0x024, 0x02C, 0x180), a write changes lower bit i only when write-data bit 16+i is 1. Reads of these registers return 0 in bits 31:16.
- R2: The general control register at 0x000 keeps the device mode in bits 7:4, driven on `dev_mode` (0x0 endpoint, 0x4 root complex), and the link-down reset grant in bit 3, driven on `rst_grant`. It resets to 0.
- R3: `train_en` follows bit 2 of the general control register whenever no training hold is active, and is 0 while a hold is active.
- R4: Legacy status at 0x008, bits 3:0: a rising edge on `intx_in[i]` sets bit i one clock later. Writing 1 to a bit clears it. A set wins over a clear in the same cycle.
- R5: The legacy mask at 0x01C, bits 7:0, resets to 0xFF. `intx_irq` is 1 exactly when some status bit 3:0 is 1 while its mask bit 3:0 is 0.
- R6: Misc status at 0x010 has bit 1 set by a rising edge of `evt_dl_chg` and bit 2 set by a rising edge of `evt_rst_req`. Both are write-1-to-clear. The misc mask at 0x024, bits 2:1, resets to 1. `misc_irq` is 1 exactly when an unmasked misc status bit is set.
- R7: The power control register at 0x02C drives `clkreq_ready` from bit 0 and `clkreq_force_low` from bits 13:12.
- R8: With bit 4 (enhanced control) and bit 1 (delayed training) both set at 0x180, a rising edge of `evt_rst_req` forces `train_en` low from the next clock. The hold lasts until a write to 0x180 with data bits 19 and 3 both 1. An event in the same cycle as that release keeps the hold. Bit 3 always reads 0.
- R9: If bit 4 or bit 1 of 0x180 is 0, a reset request does not change `train_en`.
- R10: Offset 0x300 is read-only. Bits 5:0 return `core_ltssm`, bits 17:16 return 2'b11 when `core_link_up` is 1 and 2'b00 otherwise, and all other bits are 0. Writes to it have no effect.
- R11: Reads of any other offset return 0, and writes to any other offset change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, upper half is the per-bit write enable |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| core_ltssm | input | 6 | Current LTSSM state from the core |
| core_link_up | input | 1 | Link-up indication from the core |
| intx_in | input | INTX_N | Legacy interrupt lines A..D |
| evt_dl_chg | input | 1 | Data-link-layer link-up change event |
| evt_rst_req | input | 1 | Hot reset or link-down reset request event |
| train_en | output | 1 | Link-training enable to the core |
| dev_mode | output | 4 | Device mode to the core |
| rst_grant | output | 1 | Link-down reset request grant |
| clkreq_ready | output | 1 | Clock-request ready |
| clkreq_force_low | output | 2 | Force clock request low |
| intx_irq | output | 1 | Combined legacy interrupt |
| misc_irq | output | 1 | Combined misc link interrupt |

## Verification
Some internal faults are directly visible. A wrong write-mask merge shows in the next read of the register and on the field outputs one clock after the write. A lost or late edge detector shows as a status bit that stays clear one clock after the event, and an interrupt output that stays low. A stuck training-hold flag has a different signature: `train_en` stays low after the release write, or stays high one clock after an armed reset request. The bench samples each of these at the first clock where the correct value must appear.

// File: rtl/pcr_pkg.sv
// Package: register offsets, implemented-bit masks and the write-mask merge
// shared by the client register block. Assumes a 12-bit byte address.
package pcr_pkg;
    localparam int unsigned OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_GEN     = 12'h000;
    localparam logic [OFS_W-1:0] OFS_INTX_ST = 12'h008;
    localparam logic [OFS_W-1:0] OFS_MISC_ST = 12'h010;
    localparam logic [OFS_W-1:0] OFS_INTX_MK = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_MISC_MK = 12'h024;
    localparam logic [OFS_W-1:0] OFS_PWR     = 12'h02C;
    localparam logic [OFS_W-1:0] OFS_HOT     = 12'h180;
    localparam logic [OFS_W-1:0] OFS_LTSSM   = 12'h300;

    // Implemented bits of each half-word control register
    localparam logic [15:0] IMPL_GEN     = 16'h00FC;
    localparam logic [15:0] IMPL_INTX_MK = 16'h00FF;
    localparam logic [15:0] IMPL_MISC_MK = 16'h0006;
    localparam logic [15:0] IMPL_PWR     = 16'h3001;
    localparam logic [15:0] IMPL_HOT     = 16'h0012;

    // Merge new data into old under the upper-half enable and implemented mask
    function automatic logic [15:0] wm_merge(input logic [15:0] old_q,
                                             input logic [31:0] wdata,
                                             input logic [15:0] impl);
        logic [15:0] en;
        en = wdata[31:16] & impl;
        return (old_q & ~en) | (wdata[15:0] & en);
    endfunction
endpackage

// File: rtl/pcr_wm_reg.sv
// Half-word write-masked control register.
// Assumes: wdata[31:16] is a per-bit enable for wdata[15:0]; bits outside
// IMPL are held at zero and never written.
module pcr_wm_reg #(
    parameter logic [15:0] IMPL = 16'hFFFF,
    parameter logic [15:0] RST  = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [15:0] q
);
    import pcr_pkg::*;

    logic [15:0] q_r;

    // Register update: reset value, else masked merge on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= RST & IMPL;
        else if (we)
            q_r <= wm_merge(q_r, wdata, IMPL);
    end

    assign q = q_r;

    // R1: bits whose enable was 0 must not change
    assert_wm_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((q ^ $past(q)) & ~$past(wdata[31:16])) == 16'h0));
endmodule

// File: rtl/pcr_irq_grp.sv
// Event status group: edge detect, sticky write-1-to-clear status, masked
// combined interrupt. Assumes event inputs are synchronous to clk.
module pcr_irq_grp #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic [N-1:0] rise,
    output logic         irq
);
    logic [N-1:0] evt_d;
    logic [N-1:0] st_r;
    logic [N-1:0] clr_eff;

    assign rise    = evt & ~evt_d;
    assign clr_eff = clr_we ? clr_bits : '0;

    // Previous event level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) evt_d <= '0;
        else        evt_d <= evt;
    end

    // Sticky status: set by rising edge, cleared by write-1; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= '0;
        else        st_r <= (st_r & ~clr_eff) | rise;
    end

    assign status = st_r;
    assign irq    = |(st_r & ~mask);

    // R4/R6: an edge always leaves its status bit set one clock later
    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((status & $past(rise)) == $past(rise)));

    // R5/R6: the interrupt never fires with an empty status register
    assert_irq_needs_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: rtl/pcr_train_hold.sv
// Training hold after a link reset request. Assumes rst_rise is a
// one-cycle edge and release is a one-cycle decoded write of the done bit.
module pcr_train_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic enhance,
    input  logic delay_en,
    input  logic rst_rise,
    input  logic release_wr,
    input  logic train_req,
    output logic train_en,
    output logic held
);
    logic held_r;
    logic arm;

    assign arm = enhance & delay_en & rst_rise;

    // Hold flag: set by an armed reset request, released by the done write
    always_ff @(posedge clk) begin
        if (!rst_n)          held_r <= 1'b0;
        else if (arm)        held_r <= 1'b1;
        else if (release_wr) held_r <= 1'b0;
    end

    assign held     = held_r;
    assign train_en = train_req & ~held_r;

    // R8: an armed reset request always produces a hold
    assert_hold_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> held);

    // R3: training is off whenever held
    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !train_en);

    // R9: a hold only starts from an armed request
    assert_hold_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(enhance && delay_en && rst_rise));
endmodule

// File: rtl/pcie_client_regs.sv
// PCIe client control register block: write-masked control registers,
// legacy and misc event status with masks, training hold and a read-only
// LTSSM status word. Assumes single-cycle word writes and combinational reads.
module pcie_client_regs #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned INTX_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        core_ltssm,
    input  logic              core_link_up,
    input  logic [INTX_N-1:0] intx_in,
    input  logic              evt_dl_chg,
    input  logic              evt_rst_req,
    output logic              train_en,
    output logic [3:0]        dev_mode,
    output logic              rst_grant,
    output logic              clkreq_ready,
    output logic [1:0]        clkreq_force_low,
    output logic              intx_irq,
    output logic              misc_irq
);
    import pcr_pkg::*;

    localparam int unsigned MISC_N  = 2;
    localparam int unsigned INTX_PAD = 32 - INTX_N;

    // Address decode
    logic hit_gen, hit_ist, hit_mst, hit_imk, hit_mmk, hit_pwr, hit_hot, hit_lts;
    logic hit_any;

    assign hit_gen = (bus_addr == ADDR_W'(OFS_GEN));
    assign hit_ist = (bus_addr == ADDR_W'(OFS_INTX_ST));
    assign hit_mst = (bus_addr == ADDR_W'(OFS_MISC_ST));
    assign hit_imk = (bus_addr == ADDR_W'(OFS_INTX_MK));
    assign hit_mmk = (bus_addr == ADDR_W'(OFS_MISC_MK));
    assign hit_pwr = (bus_addr == ADDR_W'(OFS_PWR));
    assign hit_hot = (bus_addr == ADDR_W'(OFS_HOT));
    assign hit_lts = (bus_addr == ADDR_W'(OFS_LTSSM));
    assign hit_any = hit_gen | hit_ist | hit_mst | hit_imk | hit_mmk |
                     hit_pwr | hit_hot | hit_lts;

    logic [15:0] gen_q, imk_q, mmk_q, pwr_q, hot_q;

    pcr_wm_reg #(.IMPL(IMPL_GEN), .RST(16'h0000)) u_gen (
        .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_gen), .wdata(bus_wdata), .q(gen_q));
    pcr_wm_reg #(.IMPL(IMPL_INTX_MK), .RST(16'h00FF)) u_imk (
        .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_imk), .wdata(bus_wdata), .q(imk_q));
    pcr_wm_reg #(.IMPL(IMPL_MISC_MK), .RST(16'h0006)) u_mmk (
        .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_mmk), .wdata(bus_wdata), .q(mmk_q));
    pcr_wm_reg #(.IMPL(IMPL_PWR), .RST(16'h0000)) u_pwr (
        .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_pwr), .wdata(bus_wdata), .q(pwr_q));
    pcr_wm_reg #(.IMPL(IMPL_HOT), .RST(16'h0000)) u_hot (
        .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_hot), .wdata(bus_wdata), .q(hot_q));

    // Legacy interrupt group
    logic [INTX_N-1:0] intx_st, intx_rise;

    pcr_irq_grp #(.N(INTX_N)) u_intx (
        .clk(clk), .rst_n(rst_n), .evt(intx_in),
        .clr_we(bus_wr & hit_ist), .clr_bits(bus_wdata[INTX_N-1:0]),
        .mask(imk_q[INTX_N-1:0]), .status(intx_st), .rise(intx_rise), .irq(intx_irq));

    // Misc link event group: index 0 = link-up change, index 1 = reset request
    logic [MISC_N-1:0] misc_st, misc_rise;

    pcr_irq_grp #(.N(MISC_N)) u_misc (
        .clk(clk), .rst_n(rst_n), .evt({evt_rst_req, evt_dl_chg}),
        .clr_we(bus_wr & hit_mst), .clr_bits(bus_wdata[2:1]),
        .mask(mmk_q[2:1]), .status(misc_st), .rise(misc_rise), .irq(misc_irq));

    // Training hold after reset request
    logic held;

    pcr_train_hold u_hold (
        .clk(clk), .rst_n(rst_n),
        .enhance(hot_q[4]), .delay_en(hot_q[1]),
        .rst_rise(misc_rise[1]),
        .release_wr(bus_wr & hit_hot & bus_wdata[19] & bus_wdata[3]),
        .train_req(gen_q[2]), .train_en(train_en), .held(held));

    assign dev_mode         = gen_q[7:4];
    assign rst_grant        = gen_q[3];
    assign clkreq_ready     = pwr_q[0];
    assign clkreq_force_low = pwr_q[13:12];

    // Read mux
    always_comb begin
        bus_rdata = 32'h0;
        if (hit_gen) bus_rdata = {16'h0, gen_q};
        if (hit_ist) bus_rdata = {{INTX_PAD{1'b0}}, intx_st};
        if (hit_mst) bus_rdata = {29'h0, misc_st, 1'b0};
        if (hit_imk) bus_rdata = {16'h0, imk_q};
        if (hit_mmk) bus_rdata = {16'h0, mmk_q};
        if (hit_pwr) bus_rdata = {16'h0, pwr_q};
        if (hit_hot) bus_rdata = {16'h0, hot_q};
        if (hit_lts) bus_rdata = {14'h0, {2{core_link_up}}, 10'h0, core_ltssm};
    end

    // R11: a write to an undefined offset leaves every control register alone
    assert_undef_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_any) |=> ($stable(gen_q) && $stable(imk_q) &&
                                  $stable(mmk_q) && $stable(pwr_q) && $stable(hot_q)));

    // R10: the read-only word reflects the core inputs
    assert_ltssm_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lts |-> (bus_rdata[5:0] == core_ltssm &&
                     bus_rdata[17:16] == {2{core_link_up}}));

    // R3: training enable never rises without the general-control request
    assert_train_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_en |-> gen_q[2] && !held);
endmodule

// File: tb/tb_pcie_client_regs.sv
module tb_pcie_client_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  core_ltssm = '0;
    logic        core_link_up = 1'b0;
    logic [3:0]  intx_in = '0;
    logic        evt_dl_chg = 1'b0;
    logic        evt_rst_req = 1'b0;
    logic        train_en, rst_grant, clkreq_ready, intx_irq, misc_irq;
    logic [3:0]  dev_mode;
    logic [1:0]  clkreq_force_low;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcie_client_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_ltssm(core_ltssm),
        .core_link_up(core_link_up), .intx_in(intx_in), .evt_dl_chg(evt_dl_chg),
        .evt_rst_req(evt_rst_req), .train_en(train_en), .dev_mode(dev_mode),
        .rst_grant(rst_grant), .clkreq_ready(clkreq_ready),
        .clkreq_force_low(clkreq_force_low), .intx_irq(intx_irq), .misc_irq(misc_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse_intx(input int i);
        @(negedge clk); intx_in[i] = 1'b1;
        @(negedge clk); intx_in[i] = 1'b0;
    endtask

    task automatic pulse_rst_req();
        @(negedge clk); evt_rst_req = 1'b1;
        @(negedge clk); evt_rst_req = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R2 gen reset", 12'h000, 32'h0);
        rd_chk("R5 intx mask reset", 12'h01C, 32'h0000_00FF);
        rd_chk("R6 misc mask reset", 12'h024, 32'h0000_0006);
        chk("R3 train_en reset", {31'h0, train_en}, 32'h0);
        chk("R5 R6 irq reset", {30'h0, intx_irq, misc_irq}, 32'h0);
    endtask

    task automatic t_wmask();
        wr(12'h000, 32'h0004_0044);
        rd_chk("R1 only enabled bit written", 12'h000, 32'h0000_0004);
        chk("R3 train_en follows bit2", {31'h0, train_en}, 32'h1);
        wr(12'h000, 32'h00F0_0040);
        rd_chk("R2 mode root complex", 12'h000, 32'h0000_0044);
        chk("R2 dev_mode", {28'h0, dev_mode}, 32'h4);
        wr(12'h000, 32'h0000_FFFF);
        rd_chk("R1 zero enables keep value", 12'h000, 32'h0000_0044);
        wr(12'h000, 32'h0008_0008);
        chk("R2 rst_grant", {31'h0, rst_grant}, 32'h1);
    endtask

    task automatic t_power();
        wr(12'h02C, 32'h3001_3001);
        rd_chk("R7 power readback", 12'h02C, 32'h0000_3001);
        chk("R7 clkreq outputs", {29'h0, clkreq_force_low, clkreq_ready}, 32'h7);
    endtask

    task automatic t_intx();
        wr(12'h01C, 32'h0002_0000);
        rd_chk("R5 unmask bit1", 12'h01C, 32'h0000_00FD);
        pulse_intx(1);
        rd_chk("R4 status bit1 set", 12'h008, 32'h2);
        chk("R5 intx_irq on", {31'h0, intx_irq}, 32'h1);
        pulse_intx(2);
        rd_chk("R4 status bit2 set", 12'h008, 32'h6);
        wr(12'h008, 32'h0000_0002);
        rd_chk("R4 write-1 clears", 12'h008, 32'h4);
        chk("R5 masked bit gives no irq", {31'h0, intx_irq}, 32'h0);
        // rising edge and clear of bit0 in the same cycle
        @(negedge clk);
        intx_in[0] = 1'b1; bus_addr = 12'h008; bus_wr = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        intx_in[0] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R4 set wins over clear", 12'h008, 32'h5);
        wr(12'h008, 32'h0000_000F);
    endtask

    task automatic t_misc();
        wr(12'h024, 32'h0006_0000);
        @(negedge clk); evt_dl_chg = 1'b1;
        @(negedge clk); evt_dl_chg = 1'b0;
        rd_chk("R6 link change bit1", 12'h010, 32'h2);
        chk("R6 misc_irq on", {31'h0, misc_irq}, 32'h1);
        wr(12'h010, 32'h0000_0002);
        rd_chk("R6 cleared", 12'h010, 32'h0);
        chk("R6 misc_irq off", {31'h0, misc_irq}, 32'h0);
    endtask

    task automatic t_hold();
        wr(12'h180, 32'h0012_0012);
        rd_chk("R8 hot control readback", 12'h180, 32'h0000_0012);
        chk("R3 train on before request", {31'h0, train_en}, 32'h1);
        pulse_rst_req();
        chk("R8 train held low", {31'h0, train_en}, 32'h0);
        rd_chk("R6 reset request bit2", 12'h010, 32'h4);
        wr(12'h000, 32'h0004_0004);
        chk("R8 gen write does not release", {31'h0, train_en}, 32'h0);
        wr(12'h180, 32'h0008_0008);
        chk("R8 done write releases", {31'h0, train_en}, 32'h1);
        rd_chk("R8 done bit reads zero", 12'h180, 32'h0000_0012);
        wr(12'h010, 32'h0000_0006);
    endtask

    task automatic t_nohold();
        wr(12'h180, 32'h0010_0000);
        pulse_rst_req();
        chk("R9 no hold without enhance", {31'h0, train_en}, 32'h1);
        wr(12'h010, 32'h0000_0006);
    endtask

    task automatic t_ltssm();
        core_ltssm = 6'h11; core_link_up = 1'b1;
        rd_chk("R10 link up word", 12'h300, 32'h0003_0011);
        core_link_up = 1'b0;
        rd_chk("R10 link down word", 12'h300, 32'h0000_0011);
        wr(12'h300, 32'hFFFF_FFFF);
        rd_chk("R10 write ignored", 12'h300, 32'h0000_0011);
        chk("R10 outputs untouched", {27'h0, dev_mode, train_en}, 32'h9);
    endtask

    task automatic t_undef();
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        rd_chk("R11 undefined read zero", 12'h004, 32'h0);
        rd_chk("R11 gen unchanged", 12'h000, 32'h0000_004C);
        rd_chk("R11 power unchanged", 12'h02C, 32'h0000_3001);
        chk("R11 outputs unchanged",
            {24'h0, dev_mode, rst_grant, train_en, clkreq_ready, intx_irq}, 32'h4E);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wmask();
        t_power();
        t_intx();
        t_misc();
        t_hold();
        t_nohold();
        t_ltssm();
        t_undef();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule